// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block drives the address side of a microprogrammed control unit. It holds a control address register that points into an external control memory. It also holds a data register that captures the microinstruction word the memory returns, and a single return-address register for micro-subroutines. The control memory is combinational and sits outside the block. It sees `car_o` and answers on `uword_i`. The micro-operation bits of the captured word leave on `ctrl_o` and stay unchanged until the next word is captured.

Each microinstruction takes two clock cycles and is sequenced by a two-state machine. In state FETCH, the word at `car_o` is registered into the data register, and the transition FETCH→EXEC is always taken. In state EXEC, the next address is chosen and loaded, and the transition EXEC→FETCH is always taken. A synchronous reset forces state FETCH from any state.

The next address comes from one of four sources:
- the current address plus one;
- the word's address field, gated by a selectable condition;
- a zero-padded mapping of the macroinstruction opcode;
- the return register.

A call flag in the word saves the return address when a branch is taken.

Top module: `mseq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the control address to 0, the return register to 0 and the data register to all zeros, and enters FETCH. While in that state, `exec_o`=0 and `ctrl_o`=0.
- R2: The microinstruction word is laid out as bits [6:0] address field, bit [7] call flag, [9:8] condition select, [11:10] next-address select and [19:12] control field. In FETCH the word at `car_o` is registered; in EXEC `exec_o` is 1 and the next address is loaded. `car_o` changes only at the EXEC→FETCH edge.
- R3: `ctrl_o` shows the control field of the registered word. It does not change while in EXEC, even if `uword_i` changes.
- R4: Select 00 loads the current address plus one, and address 127 wraps to 0.
- R5: Select 01 loads the address field when the selected condition is true. Otherwise it loads the current address plus one.
- R6: Condition select 00 is constant true, 01 is `flag_ext_i`, 10 is `flag_zero_i` and 11 is `flag_sign_i`.
- R7: Select 10 loads the mapped opcode address. This address is a 0 bit, then the four `opcode_i` bits, then two 0 bits (7 bits), so opcode 1011 gives 44.
- R8: Select 11 loads the return register.
- R9: When the call flag is set under select 01 and the condition is true, the current address plus one is written into the return register. In every other case the return register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uword_i | input | 20 | Microinstruction word from control memory |
| opcode_i | input | 4 | Macroinstruction opcode for mapping |
| flag_ext_i | input | 1 | External condition flag |
| flag_zero_i | input | 1 | Zero condition flag |
| flag_sign_i | input | 1 | Sign condition flag |
| car_o | output | 7 | Control memory address |
| ctrl_o | output | 8 | Control field of the registered word |
| exec_o | output | 1 | High in EXEC state |

## Verification
Branches are tried with each condition source set both true and false, and with the other flags set to the opposite value, which shows that the right flag is selected. Opcode mapping uses the all-zero, all-one and mixed opcodes, which exposes shifted or misplaced padding. Call and return sequences distinguish a taken call from a not-taken call, a plain branch and a mapped jump carrying the call flag. Together they show that the return register is written only when R9 allows it. A branch to address 127 followed by an increment shows the wrap.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    typedef enum logic [1:0] {
        NXT_INC    = 2'b00,
        NXT_BRANCH = 2'b01,
        NXT_MAP    = 2'b10,
        NXT_RET    = 2'b11
    } nxt_sel_e;

    typedef enum logic [1:0] {
        CND_ONE  = 2'b00,
        CND_EXT  = 2'b01,
        CND_ZERO = 2'b10,
        CND_SIGN = 2'b11
    } cnd_sel_e;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mseq_map.sv
module mseq_map #(
    parameter int OPC_W  = 4,
    parameter int PAD_HI = 1,
    parameter int PAD_LO = 2,
    parameter int ADDR_W = PAD_HI + OPC_W + PAD_LO
) (
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] map_addr
);
    localparam int LOW_W = OPC_W + PAD_LO;

    logic [LOW_W-1:0] low_part;

    generate
        if (PAD_LO > 0) begin : g_lo_pad
            assign low_part = {opcode, {PAD_LO{1'b0}}};
        end else begin : g_lo_bare
            assign low_part = opcode;
        end
        if (PAD_HI > 0) begin : g_hi_pad
            assign map_addr = {{PAD_HI{1'b0}}, low_part};
        end else begin : g_hi_bare
            assign map_addr = low_part;
        end
    endgenerate
endmodule

// File: rtl/mseq_cond.sv
module mseq_cond
    import mseq_pkg::*;
(
    input  cnd_sel_e sel,
    input  logic     flag_ext,
    input  logic     flag_zero,
    input  logic     flag_sign,
    output logic     cond_ok
);
    always_comb begin
        unique case (sel)
            CND_ONE:  cond_ok = 1'b1;
            CND_EXT:  cond_ok = flag_ext;
            CND_ZERO: cond_ok = flag_zero;
            CND_SIGN: cond_ok = flag_sign;
            default:  cond_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  nxt_sel_e          sel,
    input  logic              call,
    input  logic              cond_ok,
    input  logic [ADDR_W-1:0] car,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] link_addr,
    output logic              push
);
    assign link_addr = car + ADDR_W'(1);

    always_comb begin
        push = 1'b0;
        unique case (sel)
            NXT_INC:    nxt_addr = link_addr;
            NXT_BRANCH: begin
                nxt_addr = cond_ok ? jump_addr : link_addr;
                push     = call & cond_ok;
            end
            NXT_MAP:    nxt_addr = map_addr;
            NXT_RET:    nxt_addr = ret_addr;
            default:    nxt_addr = link_addr;
        endcase
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int PAD_HI = 1,
    parameter int PAD_LO = 2,
    parameter int CTRL_W = 8,
    localparam int ADDR_W = PAD_HI + OPC_W + PAD_LO,
    localparam int UW_W   = CTRL_W + 5 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [UW_W-1:0]   uword_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              flag_ext_i,
    input  logic              flag_zero_i,
    input  logic              flag_sign_i,
    output logic [ADDR_W-1:0] car_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              exec_o
);
    localparam int CALL_B   = ADDR_W;
    localparam int CND_LSB  = ADDR_W + 1;
    localparam int SEL_LSB  = ADDR_W + 3;
    localparam int CTRL_LSB = ADDR_W + 5;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] car_q, sbr_q;
    logic [UW_W-1:0]   cdr_q;

    logic [ADDR_W-1:0] map_addr, nxt_addr, link_addr;
    logic              cond_ok, push;

    mseq_map #(
        .OPC_W (OPC_W),
        .PAD_HI(PAD_HI),
        .PAD_LO(PAD_LO),
        .ADDR_W(ADDR_W)
    ) u_map (
        .opcode  (opcode_i),
        .map_addr(map_addr)
    );

    mseq_cond u_cond (
        .sel      (cnd_sel_e'(cdr_q[CND_LSB +: 2])),
        .flag_ext (flag_ext_i),
        .flag_zero(flag_zero_i),
        .flag_sign(flag_sign_i),
        .cond_ok  (cond_ok)
    );

    mseq_next #(
        .ADDR_W(ADDR_W)
    ) u_next (
        .sel      (nxt_sel_e'(cdr_q[SEL_LSB +: 2])),
        .call     (cdr_q[CALL_B]),
        .cond_ok  (cond_ok),
        .car      (car_q),
        .jump_addr(cdr_q[ADDR_W-1:0]),
        .map_addr (map_addr),
        .ret_addr (sbr_q),
        .nxt_addr (nxt_addr),
        .link_addr(link_addr),
        .push     (push)
    );

    always_comb begin
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            car_q   <= '0;
            sbr_q   <= '0;
            cdr_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_FETCH: cdr_q <= uword_i;
                ST_EXEC: begin
                    car_q <= nxt_addr;
                    if (push) sbr_q <= link_addr;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        car_o  = car_q;
        ctrl_o = cdr_q[CTRL_LSB +: CTRL_W];
        exec_o = (state_q == ST_EXEC);
    end
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
    parameter int OPC_W  = 4,
    parameter int PAD_LO = 2,
    parameter int CTRL_W = 8,
    parameter int ADDR_W = 7,
    parameter int UW_W   = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] car,
    input logic [ADDR_W-1:0] sbr,
    input logic [UW_W-1:0]   cdr,
    input logic [OPC_W-1:0]  opcode,
    input logic [CTRL_W-1:0] ctrl,
    input logic              exec
);
    localparam int CND_LSB = ADDR_W + 1;
    localparam int SEL_LSB = ADDR_W + 3;

    logic [1:0]        sel, cnd;
    logic [ADDR_W-1:0] map_exp;

    assign sel     = cdr[SEL_LSB +: 2];
    assign cnd     = cdr[CND_LSB +: 2];
    assign map_exp = ADDR_W'(opcode) << PAD_LO;

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (car == '0 && sbr == '0 && ctrl == '0 && !exec));

    p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
        exec |=> !exec);

    p_car_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !exec |=> $stable(car));

    p_ctrl_stable_r3: assert property (@(posedge clk) disable iff (rst)
        exec |=> $stable(ctrl));

    p_increment_r4: assert property (@(posedge clk) disable iff (rst)
        (exec && sel == 2'b00) |=> car == ADDR_W'($past(car) + 1'b1));

    p_branch_always_r5: assert property (@(posedge clk) disable iff (rst)
        (exec && sel == 2'b01 && cnd == 2'b00) |=> car == $past(cdr[ADDR_W-1:0]));

    p_map_r7: assert property (@(posedge clk) disable iff (rst)
        (exec && sel == 2'b10) |=> car == $past(map_exp));

    p_return_r8: assert property (@(posedge clk) disable iff (rst)
        (exec && sel == 2'b11) |=> car == $past(sbr));

    p_sbr_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (!exec || sel != 2'b01) |=> $stable(sbr));
endmodule

bind mseq_top mseq_checker #(
    .OPC_W (OPC_W),
    .PAD_LO(PAD_LO),
    .CTRL_W(CTRL_W),
    .ADDR_W(ADDR_W),
    .UW_W  (UW_W)
) u_mseq_checker (
    .clk   (clk),
    .rst   (rst),
    .car   (car_q),
    .sbr   (sbr_q),
    .cdr   (cdr_q),
    .opcode(opcode_i),
    .ctrl  (ctrl_o),
    .exec  (exec_o)
);

// File: tb/test_mseq_top.sv
module test_mseq_top;
    localparam int AW = 7;
    localparam int UW = 20;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [UW-1:0] uword;
    logic [3:0]    opcode = '0;
    logic          f_ext = 1'b0, f_zero = 1'b0, f_sign = 1'b0;
    logic [AW-1:0] car;
    logic [7:0]    ctrl;
    logic          exec;

    logic [UW-1:0] mem [DEPTH];

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    assign uword = mem[car];

    mseq_top i_mseq_top (
        .clk        (clk),
        .rst        (rst),
        .uword_i    (uword),
        .opcode_i   (opcode),
        .flag_ext_i (f_ext),
        .flag_zero_i(f_zero),
        .flag_sign_i(f_sign),
        .car_o      (car),
        .ctrl_o     (ctrl),
        .exec_o     (exec)
    );

    function automatic logic [UW-1:0] mk(input logic [7:0] c, input logic [1:0] s,
                                         input logic [1:0] k, input logic call,
                                         input logic [AW-1:0] a);
        return {c, s, k, call, a};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_one();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = mk(8'h11, 2'b01, 2'b00, 1'b1, 7'd9);
        do_reset();
        run_one();
        chk("R9 call jump", car, 9);
        do_reset();
        chk("R1 car", car, 0);
        chk("R1 exec", exec, 0);
        chk("R1 ctrl", ctrl, 0);
        mem[0] = mk(8'h00, 2'b01, 2'b00, 1'b0, 7'd9);
        mem[9] = mk(8'h00, 2'b11, 2'b00, 1'b0, 7'd0);
        run_one();
        run_one();
        chk("R1 return reg cleared", car, 0);
    endtask

    task automatic t_ctrl();
        clear_mem();
        mem[0] = mk(8'hA5, 2'b00, 2'b00, 1'b0, 7'd0);
        mem[1] = mk(8'h5A, 2'b00, 2'b00, 1'b0, 7'd0);
        do_reset();
        @(posedge clk); @(negedge clk);
        chk("R2 exec high", exec, 1);
        chk("R2 car held in exec", car, 0);
        chk("R3 ctrl field", ctrl, 8'hA5);
        mem[0] = mk(8'h3C, 2'b00, 2'b00, 1'b0, 7'd0);
        #1;
        chk("R3 ctrl stable", ctrl, 8'hA5);
        @(posedge clk); @(negedge clk);
        chk("R2 exec low", exec, 0);
        chk("R4 inc", car, 1);
        chk("R3 ctrl kept", ctrl, 8'hA5);
        @(posedge clk); @(negedge clk);
        chk("R2 next word", ctrl, 8'h5A);
    endtask

    task automatic t_wrap();
        clear_mem();
        mem[0]   = mk(8'h00, 2'b01, 2'b00, 1'b0, 7'd127);
        mem[127] = mk(8'h00, 2'b00, 2'b00, 1'b0, 7'd0);
        do_reset();
        run_one();
        chk("R5 branch top", car, 127);
        run_one();
        chk("R4 wrap", car, 0);
    endtask

    task automatic t_cond();
        clear_mem();
        mem[0]  = mk(8'h00, 2'b01, 2'b01, 1'b0, 7'd40);
        mem[1]  = mk(8'h00, 2'b01, 2'b01, 1'b0, 7'd40);
        mem[40] = mk(8'h00, 2'b01, 2'b10, 1'b0, 7'd50);
        mem[41] = mk(8'h00, 2'b01, 2'b10, 1'b0, 7'd50);
        mem[50] = mk(8'h00, 2'b01, 2'b11, 1'b0, 7'd60);
        mem[60] = mk(8'h00, 2'b01, 2'b11, 1'b0, 7'd90);
        mem[61] = mk(8'h00, 2'b01, 2'b00, 1'b0, 7'd3);
        do_reset();
        f_ext = 0; f_zero = 1; f_sign = 1;
        run_one(); chk("R5 R6 ext false", car, 1);
        f_ext = 1; f_zero = 0; f_sign = 0;
        run_one(); chk("R6 ext true", car, 40);
        f_ext = 1; f_zero = 0; f_sign = 1;
        run_one(); chk("R5 R6 zero false", car, 41);
        f_ext = 0; f_zero = 1; f_sign = 0;
        run_one(); chk("R6 zero true", car, 50);
        f_ext = 0; f_zero = 0; f_sign = 1;
        run_one(); chk("R6 sign true", car, 60);
        f_ext = 1; f_zero = 1; f_sign = 0;
        run_one(); chk("R5 R6 sign false", car, 61);
        f_ext = 0; f_zero = 0; f_sign = 0;
        run_one(); chk("R6 constant true", car, 3);
    endtask

    task automatic t_map();
        clear_mem();
        mem[0]  = mk(8'h00, 2'b10, 2'b00, 1'b0, 7'd0);
        mem[44] = mk(8'h00, 2'b10, 2'b00, 1'b0, 7'd0);
        mem[60] = mk(8'h00, 2'b10, 2'b00, 1'b0, 7'd0);
        mem[20] = mk(8'h00, 2'b10, 2'b00, 1'b0, 7'd0);
        do_reset();
        opcode = 4'b1011; run_one(); chk("R7 map 1011", car, 44);
        opcode = 4'b1111; run_one(); chk("R7 map 1111", car, 60);
        opcode = 4'b0101; run_one(); chk("R7 map 0101", car, 20);
        opcode = 4'b0000; run_one(); chk("R7 map 0000", car, 0);
    endtask

    task automatic t_call();
        clear_mem();
        mem[0]  = mk(8'h00, 2'b01, 2'b00, 1'b1, 7'd30);
        mem[30] = mk(8'h00, 2'b00, 2'b00, 1'b0, 7'd0);
        mem[31] = mk(8'h00, 2'b11, 2'b00, 1'b0, 7'd0);
        mem[1]  = mk(8'h00, 2'b01, 2'b01, 1'b1, 7'd70);
        mem[2]  = mk(8'h00, 2'b11, 2'b00, 1'b0, 7'd0);
        mem[90] = mk(8'h00, 2'b11, 2'b00, 1'b0, 7'd0);
        mem[8]  = mk(8'h00, 2'b11, 2'b00, 1'b0, 7'd0);
        do_reset();
        f_ext = 0;
        run_one(); chk("R9 call taken", car, 30);
        run_one(); chk("R4 in routine", car, 31);
        run_one(); chk("R8 return", car, 1);
        run_one(); chk("R9 call not taken", car, 2);
        run_one(); chk("R9 return reg kept", car, 1);
        mem[1] = mk(8'h00, 2'b01, 2'b00, 1'b0, 7'd90);
        run_one(); chk("R5 plain branch", car, 90);
        run_one(); chk("R9 plain branch no save", car, 1);
        mem[1] = mk(8'h00, 2'b10, 2'b00, 1'b1, 7'd0);
        opcode = 4'b0010;
        run_one(); chk("R7 map with call flag", car, 8);
        run_one(); chk("R9 map no save", car, 1);
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_ctrl();
        t_wrap();
        t_cond();
        t_map();
        t_call();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule